// File: doc/BRIEF.md
# PHY Test-Port Frequency-Band Programmer

This block programs the high-speed frequency-band field of a serial receiver PHY through the PHY's strobed test port. Each request carries a per-lane bit rate in Mbps. A combinational band selector turns that rate into an 8-bit band code. A sequencer then drives the test port through a fixed, edge-ordered strobe pattern. The pattern writes the code to internal PHY address 0x44.

The request side is a plain start pulse with a rate value and a rate-valid flag. When the flag is low, a default rate of 849 Mbps is used. The status side is also plain: busy, a one-cycle done pulse, and a range error that accompanies done when no band covers the rate. Every strobe phase lasts `HOLD` system clocks, which gives the PHY setup and hold margin around each test-clock edge. There is no stream data path, so the block has no valid/ready handshake. A start that arrives while busy is simply not taken.

Top module: `phy_cfg_writer`

## Requirements
- R1: After reset, busy, done, range_err, tst_clr, tst_clk, tst_en and tst_dout are all low.
- R2: An accepted request first holds tst_clr high for HOLD cycles with tst_clk, tst_en and tst_dout at zero. It then releases tst_clr and keeps all test pins at zero for HOLD more cycles.
- R3: Next, tst_clk rises while tst_en stays low. Then tst_en goes high with tst_dout = 0x44 while tst_clk is still high. Then tst_clk falls while tst_en and the address are held. Each of these phases lasts HOLD cycles.
- R4: Next, tst_en drops and tst_dout carries the band code while tst_clk is low. Then tst_clk rises and falls again, each phase HOLD cycles. After that, all test pins return to zero.
- R5: The band code is taken from the first entry, in ascending bound order, whose bound is strictly greater than the rate. The pairs (bound:code, hex) are: 90:00 100:20 110:40 125:02 140:22 150:42 160:04 180:24 200:44 210:06 240:26 250:46 270:08 300:28 330:48 360:2a 400:4a 450:0c 500:2c 550:0e 600:2e 650:10 700:30 750:12 800:32 850:14 900:34 950:54 1000:74.
- R6: With rate_vld low, the rate input is ignored and 849 is used, which gives code 0x14.
- R7: A request whose rate is 1000 or more raises done and range_err together for one cycle, in the cycle after start is sampled. No test pin moves and busy stays low.
- R8: For an accepted request, busy is high for exactly 8*HOLD cycles, starting in the cycle after start is sampled. done pulses for one cycle immediately after busy falls, with range_err low.
- R9: A start that arrives while busy is ignored. It causes no extra test-port sequence, no extra done pulse and no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, sampled on a rising clock edge |
| rate_vld | input | 1 | Rate input is meaningful; when low, the default rate is used |
| rate_mbps | input | RATE_W | Per-lane bit rate in Mbps |
| busy | output | 1 | Test-port sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| range_err | output | 1 | Rate beyond the last band; valid with done |
| tst_clr | output | 1 | PHY test-port clear |
| tst_clk | output | 1 | PHY test-port strobe |
| tst_en | output | 1 | PHY test-port address enable |
| tst_dout | output | 8 | PHY test-port address/data bus |

## Verification
A corrupted phase register shows up within one HOLD window. The test pins then leave the expected order of distinct pin patterns: an enable edge with the strobe in the wrong level, or a data byte on the bus during the address phase. A wrong band lookup appears only in the data phases, where the byte on the bus differs from the code for the requested bound. A phase counter off by one changes the busy length, which becomes visible when done arrives. A wrong acceptance gate shows as a second pin sequence or a stray done pulse after the first request completes.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

  localparam int BAND_N = 29;

  typedef enum logic [3:0] {
    PH_IDLE, PH_CLR, PH_GAP, PH_CKH, PH_ADR, PH_AFL, PH_DAT, PH_DRS, PH_FIN
  } phase_t;

  typedef struct packed {
    logic clr;
    logic ck;
    logic en;
    logic put_addr;
    logic put_data;
  } pin_plan_t;

  // upper rate bound (exclusive) of band i, ascending
  function automatic int unsigned band_bound(input int i);
    case (i)
      0: return 90;    1: return 100;   2: return 110;   3: return 125;
      4: return 140;   5: return 150;   6: return 160;   7: return 180;
      8: return 200;   9: return 210;  10: return 240;  11: return 250;
     12: return 270;  13: return 300;  14: return 330;  15: return 360;
     16: return 400;  17: return 450;  18: return 500;  19: return 550;
     20: return 600;  21: return 650;  22: return 700;  23: return 750;
     24: return 800;  25: return 850;  26: return 900;  27: return 950;
      default: return 1000;
    endcase
  endfunction

  function automatic logic [7:0] band_code(input int i);
    case (i)
      0: return 8'h00;   1: return 8'h20;   2: return 8'h40;   3: return 8'h02;
      4: return 8'h22;   5: return 8'h42;   6: return 8'h04;   7: return 8'h24;
      8: return 8'h44;   9: return 8'h06;  10: return 8'h26;  11: return 8'h46;
     12: return 8'h08;  13: return 8'h28;  14: return 8'h48;  15: return 8'h2a;
     16: return 8'h4a;  17: return 8'h0c;  18: return 8'h2c;  19: return 8'h0e;
     20: return 8'h2e;  21: return 8'h10;  22: return 8'h30;  23: return 8'h12;
     24: return 8'h32;  25: return 8'h14;  26: return 8'h34;  27: return 8'h54;
      default: return 8'h74;
    endcase
  endfunction

endpackage

// File: rtl/phy_band_sel.sv
module phy_band_sel
  import phy_cfg_pkg::*;
#(
  parameter int RATE_W   = 12,
  parameter int DEF_RATE = 849
) (
  input  logic [RATE_W-1:0] rate_mbps,
  input  logic              rate_vld,
  output logic [7:0]        code,
  output logic              miss
);

  localparam logic [RATE_W-1:0] DEF_R = RATE_W'(DEF_RATE);

  logic [RATE_W-1:0] eff_rate;
  logic [BAND_N-1:0] hit;

  assign eff_rate = rate_vld ? rate_mbps : DEF_R;

  for (genvar g = 0; g < BAND_N; g++) begin : g_cmp
    assign hit[g] = band_bound(g) > 32'(eff_rate);
  end

  // lowest-index hit wins: scan downward so the last assignment is the first hit
  always_comb begin
    code = 8'h00;
    for (int i = BAND_N - 1; i >= 0; i--) begin
      if (hit[i]) code = band_code(i);
    end
  end

  assign miss = ~|hit;

endmodule

// File: rtl/phy_strobe_seq.sv
module phy_strobe_seq
  import phy_cfg_pkg::*;
#(
  parameter int          HOLD = 2,
  parameter logic [7:0]  ADDR = 8'h44
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] code_in,
  output logic       busy,
  output logic       fin,
  output logic       tst_clr,
  output logic       tst_clk,
  output logic       tst_en,
  output logic [7:0] tst_dout
);

  localparam int CNT_W = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD - 1);

  phase_t          ph;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       code_q;
  logic             last_tick;
  pin_plan_t        plan;

  assign last_tick = (cnt == CNT_LAST);
  assign busy      = (ph != PH_IDLE);
  assign fin       = (ph == PH_FIN) && last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      code_q <= '0;
    end else if (ph == PH_IDLE) begin
      cnt <= '0;
      if (go) begin
        ph     <= PH_CLR;
        code_q <= code_in;
      end
    end else if (last_tick) begin
      cnt <= '0;
      ph  <= (ph == PH_FIN) ? PH_IDLE : phase_t'(ph + 4'd1);
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    plan = '0;
    case (ph)
      PH_CLR: plan.clr = 1'b1;
      PH_CKH: plan.ck  = 1'b1;
      PH_ADR: begin plan.ck = 1'b1; plan.en = 1'b1; plan.put_addr = 1'b1; end
      PH_AFL: begin plan.en = 1'b1; plan.put_addr = 1'b1; end
      PH_DAT: plan.put_data = 1'b1;
      PH_DRS: begin plan.ck = 1'b1; plan.put_data = 1'b1; end
      PH_FIN: plan.put_data = 1'b1;
      default: plan = '0;
    endcase
  end

  assign tst_clr  = plan.clr;
  assign tst_clk  = plan.ck;
  assign tst_en   = plan.en;
  assign tst_dout = plan.put_addr ? ADDR : (plan.put_data ? code_q : 8'h00);

endmodule

// File: rtl/phy_cfg_writer.sv
module phy_cfg_writer #(
  parameter int RATE_W   = 12,
  parameter int HOLD     = 2,
  parameter int DEF_RATE = 849
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rate_vld,
  input  logic [RATE_W-1:0] rate_mbps,
  output logic              busy,
  output logic              done,
  output logic              range_err,
  output logic              tst_clr,
  output logic              tst_clk,
  output logic              tst_en,
  output logic [7:0]        tst_dout
);

  localparam logic [7:0] BAND_ADDR = 8'h44;

  logic [7:0] sel_code;
  logic       sel_miss;
  logic       take;
  logic       seq_fin;

  phy_band_sel #(.RATE_W(RATE_W), .DEF_RATE(DEF_RATE)) u_sel (
    .rate_mbps (rate_mbps),
    .rate_vld  (rate_vld),
    .code      (sel_code),
    .miss      (sel_miss)
  );

  assign take = start & ~busy;

  phy_strobe_seq #(.HOLD(HOLD), .ADDR(BAND_ADDR)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (take & ~sel_miss),
    .code_in  (sel_code),
    .busy     (busy),
    .fin      (seq_fin),
    .tst_clr  (tst_clr),
    .tst_clk  (tst_clk),
    .tst_en   (tst_en),
    .tst_dout (tst_dout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      range_err <= 1'b0;
    end else begin
      done      <= seq_fin | (take & sel_miss);
      range_err <= take & sel_miss;
    end
  end

endmodule

// File: rtl/phy_cfg_writer_chk.sv
module phy_cfg_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic range_err,
  input logic tst_clr,
  input logic tst_clk,
  input logic tst_en
);

  // R2
  clr_leads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (tst_clr && !tst_clk && !tst_en));

  // R3
  en_rise_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tst_en) |-> tst_clk);

  // R3
  en_drop_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tst_en) |-> (!tst_clk && $past(!tst_clk)));

  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> (done && !busy && !tst_clk && !tst_en));

  // R8
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  // R9
  busy_start_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !range_err);

endmodule

bind phy_cfg_writer phy_cfg_writer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .range_err (range_err),
  .tst_clr   (tst_clr),
  .tst_clk   (tst_clk),
  .tst_en    (tst_en)
);

// File: tb/phy_cfg_writer_tb.sv
module phy_cfg_writer_tb;

  localparam int RATE_W = 12;
  localparam int HOLD   = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              rate_vld = 1'b0;
  logic [RATE_W-1:0] rate_mbps = '0;
  logic busy, done, range_err, tst_clr, tst_clk, tst_en;
  logic [7:0] tst_dout;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  phy_cfg_writer #(.RATE_W(RATE_W), .HOLD(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rate_vld(rate_vld),
    .rate_mbps(rate_mbps), .busy(busy), .done(done), .range_err(range_err),
    .tst_clr(tst_clr), .tst_clk(tst_clk), .tst_en(tst_en), .tst_dout(tst_dout)
  );

  int bounds [29] = '{90,100,110,125,140,150,160,180,200,210,240,250,270,300,
                      330,360,400,450,500,550,600,650,700,750,800,850,900,950,1000};
  int codes  [29] = '{'h00,'h20,'h40,'h02,'h22,'h42,'h04,'h24,'h44,'h06,'h26,'h46,
                      'h08,'h28,'h48,'h2a,'h4a,'h0c,'h2c,'h0e,'h2e,'h10,'h30,'h12,
                      'h32,'h14,'h34,'h54,'h74};

  // scoreboard: {clr, clk, en, dout}
  logic [10:0] exp_q [$];
  string       tag_q [$];
  logic [10:0] last_pushed = '0;
  logic [10:0] prev_sig = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [10:0] s, input string tag);
    if (s != last_pushed) begin
      exp_q.push_back(s);
      tag_q.push_back(tag);
      last_pushed = s;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      logic [10:0] cur;
      cur = {tst_clr, tst_clk, tst_en, tst_dout};
      if (cur != prev_sig) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected pin change", int'(cur), int'(prev_sig));
        end else begin
          logic [10:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(cur == e, t, int'(cur), int'(e));
        end
      end
      prev_sig = cur;
    end
  end

  task automatic do_write(input int rate, input bit vld, input bit poke);
    int eff, code, nbusy;
    bit miss;
    string dtag;
    eff  = vld ? rate : 849;
    miss = 1'b1;
    code = 0;
    for (int i = 28; i >= 0; i--) if (bounds[i] > eff) begin code = codes[i]; miss = 1'b0; end
    dtag = vld ? "R5 band code" : "R6 default code";
    if (!miss) begin
      push({3'b100, 8'h00}, "R2 clear high");
      push({3'b000, 8'h00}, "R2 clear released");
      push({3'b010, 8'h00}, "R3 strobe up");
      push({3'b011, 8'h44}, "R3 address with enable");
      push({3'b001, 8'h44}, "R3 strobe falls on address");
      push({3'b000, 8'(code)}, dtag);
      push({3'b010, 8'(code)}, "R4 strobe rises on data");
      push({3'b000, 8'(code)}, "R4 strobe low after data");
      push({3'b000, 8'h00}, "R4 bus back to zero");
    end
    @(negedge clk);
    rate_mbps = RATE_W'(rate); rate_vld = vld; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nbusy = 0;
    while (!done) begin
      if (busy) nbusy++;
      if (poke && nbusy == 2) begin start = 1'b1; rate_mbps = RATE_W'(2000); rate_vld = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    if (miss) begin
      check(range_err == 1'b1, "R7 error flag", int'(range_err), 1);
      check(nbusy == 0, "R7 busy stays low", nbusy, 0);
      check({tst_clr, tst_clk, tst_en, tst_dout} == '0, "R7 pins quiet",
            int'({tst_clr, tst_clk, tst_en, tst_dout}), 0);
    end else begin
      check(range_err == 1'b0, "R8 no error on done", int'(range_err), 0);
      check(nbusy == 8*HOLD, "R8 busy length", nbusy, 8*HOLD);
    end
    check(busy == 1'b0, "R8 busy low at done", int'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, "R8 done single cycle", int'(done), 0);
    if (poke) begin
      int extra;
      extra = 0;
      repeat (8*HOLD + 4) begin
        @(negedge clk);
        if (done || busy || range_err) extra++;
      end
      check(extra == 0, "R9 ignored start left no trace", extra, 0);
    end
    check(exp_q.size() == 0, "R4 sequence complete", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busy, done, range_err, tst_clr, tst_clk, tst_en, tst_dout} == '0,
          "R1 reset state", int'({busy, done, range_err, tst_clr, tst_clk, tst_en, tst_dout}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, tst_clr, tst_clk, tst_en} == '0, "R1 idle after reset",
          int'({busy, done, tst_clr, tst_clk, tst_en}), 0);
    do_write(50,   1'b1, 1'b0);  // R5 code 0x00
    do_write(95,   1'b1, 1'b0);  // R5 code 0x20
    do_write(90,   1'b1, 1'b0);  // R5 bound not strictly greater -> 0x20
    do_write(849,  1'b1, 1'b0);  // R5 0x14
    do_write(850,  1'b1, 1'b0);  // R5 0x34
    do_write(3000, 1'b0, 1'b0);  // R6 rate ignored, default 849
    do_write(999,  1'b1, 1'b0);  // R5 last band 0x74
    do_write(1000, 1'b1, 1'b0);  // R7 out of range
    do_write(2000, 1'b1, 1'b0);  // R7 out of range
    do_write(400,  1'b1, 1'b1);  // R9 start during busy ignored, 0x0c
    do_write(130,  1'b1, 1'b0);  // R5 0x22 after ignored start
    finish_run();
  end

endmodule